// File: doc/BRIEF.md
# Protected Backup Register Bank

This block holds sixteen 32-bit retention registers for a small memory-mapped register bus. Each access is a single-cycle strobe. A guard register at offset 0x0 gives every storage slot two flags. A read flag makes reads of that slot return zero instead of its contents. A write flag makes writes to that slot get thrown away. Protected accesses do not raise a bus error: reads quietly return zero, and a rejected write only produces a one-cycle fault pulse.

The guard register accepts one accepted write and then locks. It is writable only while the system write-lock input is low. A write refused for that reason does not use up the single opportunity. The retention-domain reset is active low and asynchronous. It stands for first power-up or loss of the backup supply, and it clears the guard, the lock, every slot and the outputs.

Top module: `guarded_retention_bank`

## Requirements
- R1: After the retention reset, the guard register, all sixteen slots, `rdData` and `accessFault` read as zero.
- R2: Slot n (n = 0..15) sits at byte offset 0x4 + 4*n. A write stores `reqWdata`. A read strobe in one cycle puts the data on `rdData` in the next cycle, and `rdData` holds it until the next read.
- R3: The first accepted write to offset 0x0 loads the guard register and locks it. Every later write to 0x0 leaves it unchanged and pulses `accessFault`.
- R4: A write to 0x0 while `sysWrLockEn` is high changes nothing, pulses `accessFault`, and leaves the one-time write still available.
- R5: When guard bit 16+n is set, a read of slot n returns 0x00000000. Writes to that slot still land if its write flag is clear.
- R6: When guard bit n is set, a write to slot n is discarded and `accessFault` goes high for one cycle.
- R7: A read of offset 0x0 always returns the current guard value. The lock state does not appear in it.
- R8: Offsets above 0x40, and offsets that are not a multiple of 4, read as zero. Writes to them change nothing and raise no fault.
- R9: Asserting the retention reset clears the lock, so the guard register can be written once again.
- R10: `accessFault` is high only in the cycle after a rejected write. It stays low after writes that were permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstRetN | input | 1 | Retention-domain reset, active low, asynchronous |
| sysWrLockEn | input | 1 | System write-lock; high blocks guard writes |
| reqRd | input | 1 | Read strobe, one cycle |
| reqWr | input | 1 | Write strobe, one cycle |
| reqAddr | input | ADDR_W | Byte offset |
| reqWdata | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| accessFault | output | 1 | One-cycle pulse after a blocked write |

## Verification
The embedded assertions assume that read and write strobes are sampled only after the retention reset has been released. They also assume that `sysWrLockEn` changes only between clock edges. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. Reads and writes never share a cycle, because the bench issues each access from its own task. The retention reset is applied only while no strobe is active.

// File: rtl/retbank_pkg.sv
package retbank_pkg;
  localparam int NUM_SLOTS = 16;
  localparam int DATA_W    = 32;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  typedef struct packed {
    logic                 modeWr;
    logic [NUM_SLOTS-1:0] slotWr;
    logic                 rdEn;
    logic                 rdMode;
    logic [NUM_SLOTS-1:0] slotRd;
    logic                 fault;
  } bankStrobe_t;
endpackage

// File: rtl/retbank_ctrl.sv
module retbank_ctrl
  import retbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstRetN,
  input  logic              sysWrLockEn,
  input  logic              reqRd,
  input  logic              reqWr,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] modeQ,
  input  logic              locked,
  output bankStrobe_t       strobe
);
  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] slotIdxFull;
  logic [SLOT_W-1:0] slotIdx;
  logic             isMode;
  logic             isSlot;
  logic             modeOk;
  logic             slotOk;

  assign aligned     = (reqAddr[1:0] == 2'b00);
  assign idx         = reqAddr[ADDR_W-1:2];
  assign slotIdxFull = idx - IDX_W'(1);
  assign slotIdx     = slotIdxFull[SLOT_W-1:0];
  assign isMode      = aligned && (idx == '0);
  assign isSlot      = aligned && (idx != '0) && (idx <= IDX_W'(NUM_SLOTS));
  assign modeOk      = !sysWrLockEn && !locked;
  assign slotOk      = !modeQ[slotIdx];

  always_comb begin
    strobe        = '0;
    strobe.rdEn   = reqRd;
    strobe.rdMode = reqRd && isMode;
    if (reqRd && isSlot) strobe.slotRd[slotIdx] = 1'b1;
    if (reqWr && isMode) begin
      strobe.modeWr = modeOk;
      strobe.fault  = !modeOk;
    end else if (reqWr && isSlot) begin
      strobe.slotWr[slotIdx] = slotOk;
      strobe.fault           = !slotOk;
    end
  end

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstRetN)
    $onehot0({strobe.modeWr, strobe.slotWr})) else $error("two write targets"); // R2
  AST_READ_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstRetN)
    $onehot0({strobe.rdMode, strobe.slotRd})) else $error("two read sources"); // R2
endmodule

// File: rtl/retbank_datapath.sv
module retbank_datapath
  import retbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstRetN,
  input  bankStrobe_t       strobe,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] modeQ,
  output logic              locked,
  output logic [DATA_W-1:0] rdData,
  output logic              accessFault
);
  logic [DATA_W-1:0] slotQ [NUM_SLOTS];
  logic [DATA_W-1:0] slotVis [NUM_SLOTS];
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk or negedge rstRetN) begin
    if (!rstRetN) begin
      modeQ  <= '0;
      locked <= 1'b0;
    end else if (strobe.modeWr) begin
      modeQ  <= reqWdata;
      locked <= 1'b1;
    end
  end

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    always_ff @(posedge clk or negedge rstRetN) begin
      if (!rstRetN) slotQ[n] <= '0;
      else if (strobe.slotWr[n]) slotQ[n] <= reqWdata;
    end
    assign slotVis[n] = (strobe.slotRd[n] && !modeQ[NUM_SLOTS+n]) ? slotQ[n] : '0;

    AST_WP_SLOT_STABLE: assert property (@(posedge clk) disable iff (!rstRetN)
      modeQ[n] |=> $stable(slotQ[n])) else $error("protected slot changed"); // R6
    AST_RP_READS_ZERO: assert property (@(posedge clk) disable iff (!rstRetN)
      (strobe.slotRd[n] && modeQ[NUM_SLOTS+n]) |=> (rdData == '0)) else $error("masked read leaked"); // R5
  end

  always_comb begin
    rdNext = strobe.rdMode ? modeQ : '0;
    for (int n = 0; n < NUM_SLOTS; n++) rdNext = rdNext | slotVis[n];
  end

  always_ff @(posedge clk or negedge rstRetN) begin
    if (!rstRetN) begin
      rdData      <= '0;
      accessFault <= 1'b0;
    end else begin
      if (strobe.rdEn) rdData <= rdNext;
      accessFault <= strobe.fault;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstRetN)
    locked |=> locked) else $error("lock dropped"); // R3
  AST_LOCKED_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rstRetN)
    locked |=> $stable(modeQ)) else $error("guard changed after lock"); // R3
endmodule

// File: rtl/guarded_retention_bank.sv
module guarded_retention_bank
  import retbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstRetN,
  input  logic              sysWrLockEn,
  input  logic              reqRd,
  input  logic              reqWr,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic [31:0]       rdData,
  output logic              accessFault
);
  bankStrobe_t       strobe;
  logic [DATA_W-1:0] modeQ;
  logic              locked;

  retbank_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstRetN(rstRetN), .sysWrLockEn(sysWrLockEn),
    .reqRd(reqRd), .reqWr(reqWr), .reqAddr(reqAddr),
    .modeQ(modeQ), .locked(locked), .strobe(strobe)
  );

  retbank_datapath i_dp (
    .clk(clk), .rstRetN(rstRetN), .strobe(strobe), .reqWdata(reqWdata),
    .modeQ(modeQ), .locked(locked), .rdData(rdData), .accessFault(accessFault)
  );

  AST_LOCK_NEEDS_SYS_LOW: assert property (@(posedge clk) disable iff (!rstRetN)
    $rose(locked) |-> $past(!sysWrLockEn)) else $error("locked while system lock high"); // R4
  AST_FAULT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstRetN)
    accessFault |-> $past(reqWr)) else $error("fault without a write"); // R10
endmodule

// File: tb/test_guarded_retention_bank.sv
module test_guarded_retention_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstRetN = 1'b0;
  logic        sysWrLockEn = 1'b0;
  logic        reqRd = 1'b0;
  logic        reqWr = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [31:0] rdData;
  logic        accessFault;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  guarded_retention_bank #(.ADDR_W(8)) i_guarded_retention_bank (
    .clk(clk), .rstRetN(rstRetN), .sysWrLockEn(sysWrLockEn),
    .reqRd(reqRd), .reqWr(reqWr), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdData(rdData), .accessFault(accessFault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, input logic expFault, input string req);
    @(negedge clk);
    reqWr = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqWr = 1'b0;
    check(req, {31'd0, accessFault}, {31'd0, expFault});
  endtask

  task automatic busRead(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reqRd = 1'b1; reqAddr = a;
    @(negedge clk);
    reqRd = 1'b0;
    check(req, rdData, exp);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstRetN = 1'b0;
    @(negedge clk);
    rstRetN = 1'b1;
  endtask

  task automatic tReset();
    check("R1 rdData", rdData, 32'h0);
    check("R1 fault", {31'd0, accessFault}, 32'h0);
    busRead(8'h00, 32'h0, "R1 guard");
    busRead(8'h18, 32'h0, "R1 slot5");
  endtask

  task automatic tBasic();
    busWrite(8'h04, 32'hA5A5_0000, 1'b0, "R10 slot0 write");
    busWrite(8'h40, 32'h5A5A_000F, 1'b0, "R10 slot15 write");
    busRead(8'h04, 32'hA5A5_0000, "R2 slot0");
    busRead(8'h40, 32'h5A5A_000F, "R2 slot15");
    @(negedge clk);
    check("R2 hold", rdData, 32'h5A5A_000F);
  endtask

  task automatic tSysLock();
    sysWrLockEn = 1'b1;
    busWrite(8'h00, 32'hFFFF_FFFF, 1'b1, "R4 fault");
    @(negedge clk);
    check("R10 single pulse", {31'd0, accessFault}, 32'h0);
    busRead(8'h00, 32'h0, "R4 guard unchanged");
    sysWrLockEn = 1'b0;
  endtask

  task automatic tProtect();
    busWrite(8'h10, 32'h1234_5678, 1'b0, "R2 slot3 write");
    busWrite(8'h20, 32'hCAFE_0007, 1'b0, "R2 slot7 write");
    busWrite(8'h00, 32'h0008_0080, 1'b0, "R4 write allowed after refusal");
    busRead(8'h00, 32'h0008_0080, "R7 guard value");
    busRead(8'h10, 32'h0, "R5 slot3 masked");
    busRead(8'h20, 32'hCAFE_0007, "R2 slot7 readable");
    busWrite(8'h20, 32'hDEAD_BEEF, 1'b1, "R6 fault");
    busRead(8'h20, 32'hCAFE_0007, "R6 slot7 kept");
    busWrite(8'h10, 32'h0000_0033, 1'b0, "R5 write lands");
    busRead(8'h10, 32'h0, "R5 still masked");
  endtask

  task automatic tWriteOnce();
    busWrite(8'h00, 32'h0, 1'b1, "R3 second write fault");
    busRead(8'h00, 32'h0008_0080, "R3 guard locked");
  endtask

  task automatic tUnmapped();
    busWrite(8'h44, 32'h1111_1111, 1'b0, "R8 write no fault");
    busRead(8'h44, 32'h0, "R8 read 0x44");
    busRead(8'h06, 32'h0, "R8 read unaligned");
    busWrite(8'h05, 32'h2222_2222, 1'b0, "R8 unaligned write");
    busRead(8'h04, 32'hA5A5_0000, "R8 slot0 intact");
  endtask

  task automatic tRetReset();
    applyReset();
    busRead(8'h04, 32'h0, "R9 slot0 cleared");
    busRead(8'h00, 32'h0, "R9 guard cleared");
    busWrite(8'h00, 32'h0000_0001, 1'b0, "R9 rewrite allowed");
    busRead(8'h00, 32'h0000_0001, "R9 guard rewritten");
    busWrite(8'h04, 32'h7, 1'b1, "R6 slot0 blocked");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rstRetN = 1'b1;
    tReset();
    tBasic();
    tSysLock();
    tProtect();
    tWriteOnce();
    tUnmapped();
    tRetReset();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule